// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt conditions of twelve DMA channels into a twelve-bit interrupt bus. Channels 0 to 9 serve peripherals and channels 10 and 11 copy memory to memory. All twelve are handled the same way. Each channel has three conditions: transfer complete, stalled, and next buffer wanted. A single-cycle event pulse on a condition latches a sticky raw bit.

Each channel also has a three-bit enable register. A channel's interrupt line is the OR of its raw bits that are enabled.

Software uses a small synchronous register port. It can read and write the enables, read the raw bits and clear them by writing ones, and read a global word that mirrors the interrupt bus. The logic that generates the events sits outside this block.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every enable and raw bit is 0, `irq_o` is 0 and every register reads 0.
- R2: A one-cycle pulse on `evt_done_i[c]`, `evt_stall_i[c]` or `evt_nfb_i[c]` sets raw bit 0, 1 or 2 of channel c at that clock edge. The bit stays set until software clears it.
- R3: `irq_o[c]` is high exactly when channel c has at least one raw bit set whose enable bit is also set. It follows the state updated at the same edge, with no further delay.
- R4: The status register shows the raw bits whatever the enables are. A raw bit whose enable is 0 does not raise `irq_o`.
- R5: A write to the status register at address 0x10+c clears each raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 are unchanged.
- R6: If an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R7: The control register at address 0x00+c holds the enables in bits [2:0], with done in bit 0, stall in bit 1 and next-buffer in bit 2. It reads back what was written. Writes to other addresses leave it unchanged.
- R8: The global register at address 0x20 reads `irq_o`, with bit c for channel c (bits 10 and 11 are the memory-to-memory channels). Writes to it have no effect.
- R9: Read data appears on `reg_rdata_o` one cycle after `reg_re_i` is sampled and holds until the next read. Unmapped addresses read 0. This includes a channel index of 12 or more, and any offset other than 0 in the global region.
- R10: A change of enable reaches `irq_o` right after the write edge. Enabling a source that is already pending raises the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_done_i | input | 12 | Transfer-complete event pulse, one bit per channel |
| evt_stall_i | input | 12 | Stall event pulse, one bit per channel |
| evt_nfb_i | input | 12 | Next-buffer event pulse, one bit per channel |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address: [5:4] region, [3:0] channel |
| reg_wdata_i | input | 3 | Write data: enables, or bits to clear |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 12 | Per-channel interrupt bus |

## Verification
An event pulse or a register write updates the latched state at the clock edge that samples it. `irq_o` reflects that state from the same edge, so the bench checks the bus at the falling edge right after the stimulus edge. Read data is due one edge after the read strobe is sampled. The read driver queues the value it expects from its own model of enables and raw bits. A monitor pops that value and compares it against `reg_rdata_o` at the falling edge that follows the sampling edge. The same-cycle race between an event and a clear, and reads of unmapped addresses, are driven as dedicated cases.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_DONE  = 2'd0,
    SRC_STALL = 2'd1,
    SRC_NFB   = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    RGN_CTRL = 2'b00,
    RGN_STAT = 2'b01,
    RGN_GLB  = 2'b10,
    RGN_NONE = 2'b11
  } rgn_e;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            en_we_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] raw_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q, raw_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      raw_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      // set beats clear
      raw_q <= (raw_q & ~clr_mask) | evt_i;
    end
  end

  assign en_o  = en_q;
  assign raw_o = raw_q;
  assign irq_o = |(raw_q & en_q);

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R2
  raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((~raw_q & $past(raw_q)) == '0));

  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(wdata_i & ~evt_i)) |=> ((raw_q & $past(wdata_i & ~evt_i)) == '0));

  // R7
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q));
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int N_CH   = 12,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       re_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [N_CH-1:0][NSRC-1:0]  en_i,
  input  logic [N_CH-1:0][NSRC-1:0]  raw_i,
  input  logic [N_CH-1:0]            irq_i,
  output logic [N_CH-1:0]            en_we_o,
  output logic [N_CH-1:0]            clr_we_o,
  output logic [DATA_W-1:0]          rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  rgn_e             rgn;
  logic [IDX_W-1:0] idx;
  logic             idx_ok, glb_hit, mapped;
  logic [DATA_W-1:0] rd_nxt, rdata_q;

  assign rgn     = rgn_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx     = addr_i[IDX_W-1:0];
  assign idx_ok  = int'(idx) < N_CH;
  assign glb_hit = (rgn == RGN_GLB) && (idx == '0);
  assign mapped  = glb_hit || (idx_ok && (rgn == RGN_CTRL || rgn == RGN_STAT));

  for (genvar c = 0; c < N_CH; c++) begin : g_we
    assign en_we_o[c]  = we_i && (rgn == RGN_CTRL) && (idx == IDX_W'(c));
    assign clr_we_o[c] = we_i && (rgn == RGN_STAT) && (idx == IDX_W'(c));
  end

  always_comb begin
    rd_nxt = '0;
    if (glb_hit) begin
      rd_nxt[N_CH-1:0] = irq_i;
    end else if (idx_ok) begin
      if (rgn == RGN_CTRL)      rd_nxt[NSRC-1:0] = en_i[idx];
      else if (rgn == RGN_STAT) rd_nxt[NSRC-1:0] = raw_i[idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_nxt;
  end

  assign rdata_o = rdata_q;

  // R8
  glb_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && glb_hit) |=> (rdata_o[N_CH-1:0] == $past(irq_i)));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> (rdata_o == '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int N_CH   = 12,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   evt_done_i,
  input  logic [N_CH-1:0]   evt_stall_i,
  input  logic [N_CH-1:0]   evt_nfb_i,
  input  logic              reg_re_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0][NSRC-1:0] en, raw;
  logic [N_CH-1:0]           en_we, clr_we;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [NSRC-1:0] evt;
    always_comb begin
      evt = '0;
      evt[SRC_DONE]  = evt_done_i[c];
      evt[SRC_STALL] = evt_stall_i[c];
      evt[SRC_NFB]   = evt_nfb_i[c];
    end

    dma_irq_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt),
      .en_we_i  (en_we[c]),
      .clr_we_i (clr_we[c]),
      .wdata_i  (reg_wdata_i),
      .en_o     (en[c]),
      .raw_o    (raw[c]),
      .irq_o    (irq_o[c])
    );
  end

  dma_irq_regif #(
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .re_i     (reg_re_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .en_i     (en),
    .raw_i    (raw),
    .irq_i    (irq_o),
    .en_we_o  (en_we),
    .clr_we_o (clr_we),
    .rdata_o  (reg_rdata_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (irq_o == '0));

  // R10
  en_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == '0 && reg_wdata_i == '0 && evt_done_i == '0)
      |=> !irq_o[0]);
endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] evt_done = '0, evt_stall = '0, evt_nfb = '0;
  logic        re = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [2:0]  wdata = '0;
  logic [15:0] rdata;
  logic [N-1:0] irq;

  always #2.5 clk = ~clk;

  dma_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_done_i(evt_done), .evt_stall_i(evt_stall), .evt_nfb_i(evt_nfb),
    .reg_re_i(re), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic [2:0] en_m [N];
  logic [2:0] raw_m [N];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_irq();
    logic [N-1:0] v = '0;
    for (int c = 0; c < N; c++) v[c] = |(raw_m[c] & en_m[c]);
    return v;
  endfunction

  function automatic logic [15:0] model_rd(input logic [5:0] a);
    logic [15:0] v = '0;
    int i = int'(a[3:0]);
    case (a[5:4])
      2'b00: if (i < N) v[2:0] = en_m[i];
      2'b01: if (i < N) v[2:0] = raw_m[i];
      2'b10: if (i == 0) v[N-1:0] = model_irq();
      default: v = '0;
    endcase
    return v;
  endfunction

  // monitor
  always @(posedge clk) rd_pend <= re;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk);
    re = 1'b1; addr = a; we = 1'b0;
    exp_q.push_back(model_rd(a));
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [2:0] d);
    int i = int'(a[3:0]);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (i < N) begin
      if (a[5:4] == 2'b00) en_m[i] = d;
      if (a[5:4] == 2'b01) raw_m[i] = raw_m[i] & ~d;
    end
  endtask

  task automatic pulse(input int c, input int s);
    @(negedge clk);
    case (s)
      0: evt_done[c] = 1'b1;
      1: evt_stall[c] = 1'b1;
      default: evt_nfb[c] = 1'b1;
    endcase
    @(negedge clk);
    evt_done = '0; evt_stall = '0; evt_nfb = '0;
    raw_m[c][s] = 1'b1;
  endtask

  task automatic chk_irq(input string tag);
    check({4'b0, irq}, {4'b0, model_irq()}, tag);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < N; c++) begin en_m[c] = '0; raw_m[c] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1
    @(negedge clk);
    chk_irq("R1 irq after reset");
    rd(6'h00, "R1 ctrl0 reset");
    rd(6'h13, "R1 stat3 reset");
    rd(6'h20, "R1 global reset");
    // R2 R4: disabled event latches but no irq
    pulse(3, 0);
    chk_irq("R4 disabled source no irq");
    rd(6'h13, "R2 stat3 done set");
    repeat (3) @(negedge clk);
    rd(6'h13, "R2 stat3 sticky");
    // R7 R10 R3
    wr(6'h03, 3'b001);
    chk_irq("R10 enable pending raises irq");
    rd(6'h03, "R7 ctrl3 readback");
    pulse(3, 1);
    rd(6'h13, "R2 stat3 stall set");
    chk_irq("R3 irq with done+stall");
    // R5 partial clear
    wr(6'h13, 3'b001);
    rd(6'h13, "R5 clear done keeps stall");
    chk_irq("R4 stall raw but disabled");
    rd(6'h03, "R7 ctrl3 unchanged by stat write");
    wr(6'h03, 3'b111);
    chk_irq("R10 enable stall");
    rd(6'h20, "R8 global ch3");
    // R8 memory channels
    wr(6'h0B, 3'b100);
    pulse(11, 2);
    chk_irq("R3 ch11 nfb");
    wr(6'h0A, 3'b001);
    pulse(10, 0);
    pulse(10, 1);
    chk_irq("R3 ch10 done");
    rd(6'h20, "R8 global with m2m");
    rd(6'h1A, "R2 ch10 two sources");
    // R6 event vs clear same cycle
    @(negedge clk);
    we = 1'b1; addr = 6'h13; wdata = 3'b010; evt_stall[3] = 1'b1;
    @(negedge clk);
    we = 1'b0; evt_stall = '0;
    rd(6'h13, "R6 set beats clear");
    // R5 zero write no change
    wr(6'h13, 3'b000);
    rd(6'h13, "R5 zero write no change");
    // R8 write to global ignored
    wr(6'h20, 3'b111);
    rd(6'h20, "R8 global write ignored");
    chk_irq("R8 irq after global write");
    // R9 unmapped
    rd(6'h30, "R9 unmapped region");
    rd(6'h0C, "R9 ctrl idx 12");
    rd(6'h21, "R9 global offset 1");
    // ch0 pattern, full clear
    pulse(0, 2);
    pulse(0, 0);
    rd(6'h10, "R2 ch0 nfb+done");
    wr(6'h00, 3'b100);
    chk_irq("R3 ch0 nfb enabled");
    wr(6'h10, 3'b111);
    chk_irq("R5 ch0 cleared drops irq");
    rd(6'h10, "R5 ch0 all clear");
    wr(6'h1B, 3'b100);
    chk_irq("R5 ch11 clear");
    wr(6'h03, 3'b000);
    chk_irq("R10 disable drops ch3");
    rd(6'h20, "R8 global final");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule